// File: doc/BRIEF.md
# Overcurrent Trip Filter and Retry Sequencer

This block sits between a digital overcurrent comparator and the gate driver of an external power switch. It synchronizes the comparator output, ignores overcurrent bursts that are too short to matter, and, when a burst lasts long enough, drops the gate enable at once. After a fixed back-off it re-enables the gate to see whether the fault has gone. If the fault is still there, the trip, back-off and retry cycle repeats.

A mode strap chooses between two behaviours. In the first, retries never stop. In the second, a bounded number of retries is allowed, after which the block locks the gate off and raises a sticky failure flag. That flag is cleared only by a manual reset or a power-on reset. The block also drives a threshold-select line for the analog comparator path. The line picks the relaxed inrush threshold, three times the normal level, until power-good has been seen, and the normal threshold after that.

All delays count a time-base tick of `TICK_DIV` clock cycles. With the defaults on a 250 MHz clock that tick is 1 µs, so the filter is 5 µs and the back-off is 100 ms.

Top module: `oc_retry_ctrl`

## Requirements
- R1: `oc_i` passes through a two-flop synchronizer. A trip happens on the (FILT_TICKS+1)-th consecutive tick at which the synchronized overcurrent is high while the gate is enabled, and any low sample restarts the count. With TICK_DIV=1 the gate therefore falls FILT_TICKS+3 clock edges after the first edge that samples `oc_i` high. A pulse of FILT_TICKS cycles or fewer leaves the gate high.
- R2: `gate_en_o` goes low in the cycle after a trip. It stays low for exactly RETRY_TICKS ticks and then returns high.
- R3: If the fault persists, every re-enabled gate window lasts FILT_TICKS+1 ticks before it trips again, followed by another RETRY_TICKS back-off.
- R4: With `limit_i`=0, `far_o` never asserts and the trip and retry cycle continues for as long as the fault lasts.
- R5: With `limit_i`=1, the trip that follows the MAX_RETRY-th retry (trip number MAX_RETRY+1) locks the block. `gate_en_o` stays 0 and `far_o` is 1 from the next cycle on.
- R6: While `mrst_i` is 1, `gate_en_o` is 0. A clock edge with `mrst_i`=1 clears `far_o`, the retry count and any back-off. When `mrst_i` falls, `gate_en_o` returns to 1 in the same cycle.
- R7: `thr_relax_o` is 1 (relaxed inrush threshold) from reset until an edge samples `pg_i`=1. It is 0 (normal threshold) from the next cycle until `rst` or `mrst_i`, and later changes of `pg_i` do not affect it.
- R8: When the gate has stayed enabled with `pg_i`=1 for FILT_TICKS+1 consecutive ticks, the retry count returns to zero, so a later fault gets the full MAX_RETRY retries again.
- R9: After `rst` (active high, synchronous), `gate_en_o`=1, `far_o`=0 and `thr_relax_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, active high, synchronous |
| mrst_i | input | 1 | Manual reset, active high |
| oc_i | input | 1 | Asynchronous overcurrent comparator output |
| pg_i | input | 1 | Power-good indication |
| limit_i | input | 1 | 1 = bounded retries with lockout, 0 = unlimited retries |
| gate_en_o | output | 1 | Enable for the external switch gate driver |
| far_o | output | 1 | Sticky failure-after-retry flag |
| thr_relax_o | output | 1 | 1 = relaxed insertion threshold, 0 = normal threshold |

## Verification
The filter is driven with a family of overcurrent pulses whose lengths straddle the filter window. Only pulses longer than FILT_TICKS cycles may remove the gate, which separates a correct window from one that is too short by a single count. A fault held continuously checks the exact back-off and re-trip edges in both strap modes. In limited mode, the edge where the lockout appears is distinguished from one trip earlier or later. A second limited-mode fault that arrives after a clean power-good period tests whether the retry count was cleared. Manual reset and power-good toggling are applied around a lockout and around the threshold flag, to tell a sticky flag from one that follows its input.

// File: rtl/ocr_pkg.sv
package ocr_pkg;

    typedef enum logic [1:0] {
        SEQ_ARMED   = 2'd0,
        SEQ_BACKOFF = 2'd1,
        SEQ_LOCKED  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic gate_on;
        logic locked;
    } seq_out_t;

    // bits needed to hold values 0..maxval
    function automatic int val_w(input int maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/ocr_tick.sv
module ocr_tick #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    import ocr_pkg::*;

    localparam int CW = val_w(DIV - 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == LAST) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick_o = (cnt == LAST);

endmodule

// File: rtl/ocr_sync.sv
module ocr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/ocr_filter.sv
module ocr_filter #(
    parameter int FILT_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic en_i,
    input  logic oc_s_i,
    output logic trip_o
);
    import ocr_pkg::*;

    localparam int FW = val_w(FILT_TICKS);
    localparam logic [FW-1:0] FULL = FW'(FILT_TICKS);

    logic [FW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || !en_i || !oc_s_i) run <= '0;
        else if (tick_i && run != FULL) run <= run + 1'b1;
    end

    assign trip_o = en_i && oc_s_i && tick_i && (run == FULL);

    // R1: a trip needs the synchronized fault already present one cycle earlier
    a_r1_trip_needs_run: assert property (@(posedge clk) disable iff (rst)
        trip_o |-> $past(oc_s_i));

    // R1: a low sample leaves no trip possible in the next cycle
    a_r1_low_restarts: assert property (@(posedge clk) disable iff (rst)
        !oc_s_i |=> !trip_o);

endmodule

// File: rtl/ocr_seq.sv
module ocr_seq #(
    parameter int FILT_TICKS  = 5,
    parameter int RETRY_TICKS = 100000,
    parameter int MAX_RETRY   = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic mrst_i,
    input  logic tick_i,
    input  logic trip_i,
    input  logic pg_i,
    input  logic limit_i,
    output ocr_pkg::seq_out_t out_o
);
    import ocr_pkg::*;

    localparam int TW = val_w(RETRY_TICKS - 1);
    localparam int RW = val_w(MAX_RETRY);
    localparam int SW = val_w(FILT_TICKS);
    localparam logic [TW-1:0] T_LAST = TW'(RETRY_TICKS - 1);
    localparam logic [RW-1:0] R_MAX  = RW'(MAX_RETRY);
    localparam logic [SW-1:0] S_FULL = SW'(FILT_TICKS);

    seq_state_e    state;
    logic [TW-1:0] timer;
    logic [RW-1:0] retries;
    logic [SW-1:0] stable;

    always_ff @(posedge clk) begin
        if (rst || mrst_i) begin
            state   <= SEQ_ARMED;
            timer   <= '0;
            retries <= '0;
            stable  <= '0;
        end else begin
            case (state)
                SEQ_ARMED: begin
                    if (trip_i) begin
                        timer  <= '0;
                        stable <= '0;
                        state  <= (limit_i && retries == R_MAX) ? SEQ_LOCKED
                                                                 : SEQ_BACKOFF;
                    end else if (!pg_i) begin
                        stable <= '0;
                    end else if (tick_i) begin
                        if (stable == S_FULL) retries <= '0;
                        else                  stable  <= stable + 1'b1;
                    end
                end
                SEQ_BACKOFF: begin
                    if (tick_i) begin
                        if (timer == T_LAST) begin
                            timer <= '0;
                            state <= SEQ_ARMED;
                            if (retries != R_MAX) retries <= retries + 1'b1;
                        end else begin
                            timer <= timer + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_LOCKED;
            endcase
        end
    end

    assign out_o.gate_on = (state == SEQ_ARMED) && !mrst_i;
    assign out_o.locked  = (state == SEQ_LOCKED);

    // R2: a trip removes the gate in the following cycle
    a_r2_trip_drops: assert property (@(posedge clk) disable iff (rst)
        trip_i |=> !out_o.gate_on);

    // R2: the back-off timer never runs past its window
    a_r2_timer_bound: assert property (@(posedge clk) disable iff (rst)
        timer <= T_LAST);

    // R4: unlimited mode never produces a new lockout
    a_r4_no_lock: assert property (@(posedge clk) disable iff (rst)
        (!limit_i && !out_o.locked) |=> !out_o.locked);

    // R5: a lockout holds and keeps the gate off until manual reset
    a_r5_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (out_o.locked && !mrst_i) |=> (out_o.locked && !out_o.gate_on));

    // R6: manual reset clears the lockout
    a_r6_mr_clears: assert property (@(posedge clk) disable iff (rst)
        mrst_i |=> !out_o.locked);

endmodule

// File: rtl/oc_retry_ctrl.sv
module oc_retry_ctrl #(
    parameter int TICK_DIV    = 250,
    parameter int FILT_TICKS  = 5,
    parameter int RETRY_TICKS = 100000,
    parameter int MAX_RETRY   = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic mrst_i,
    input  logic oc_i,
    input  logic pg_i,
    input  logic limit_i,
    output logic gate_en_o,
    output logic far_o,
    output logic thr_relax_o
);
    import ocr_pkg::*;

    logic     tick;
    logic     oc_sync;
    logic     trip;
    logic     pg_seen;
    seq_out_t seq_out;

    generate
        if (TICK_DIV > 1) begin : g_div
            ocr_tick #(.DIV(TICK_DIV)) u_tick (
                .clk    (clk),
                .rst    (rst),
                .tick_o (tick)
            );
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    ocr_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (oc_i),
        .q_o (oc_sync)
    );

    ocr_filter #(.FILT_TICKS(FILT_TICKS)) u_filter (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .en_i   (seq_out.gate_on),
        .oc_s_i (oc_sync),
        .trip_o (trip)
    );

    ocr_seq #(
        .FILT_TICKS  (FILT_TICKS),
        .RETRY_TICKS (RETRY_TICKS),
        .MAX_RETRY   (MAX_RETRY)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .mrst_i  (mrst_i),
        .tick_i  (tick),
        .trip_i  (trip),
        .pg_i    (pg_i),
        .limit_i (limit_i),
        .out_o   (seq_out)
    );

    always_ff @(posedge clk) begin
        if (rst || mrst_i) pg_seen <= 1'b0;
        else if (pg_i)     pg_seen <= 1'b1;
    end

    assign gate_en_o   = seq_out.gate_on;
    assign far_o       = seq_out.locked;
    assign thr_relax_o = !pg_seen;

    // R7: the normal threshold, once chosen, stays until a reset
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (!thr_relax_o && !mrst_i) |=> !thr_relax_o);

    // R7: the switch to the normal threshold is caused by power-good
    a_r7_needs_pg: assert property (@(posedge clk) disable iff (rst)
        $fell(thr_relax_o) |-> $past(pg_i));

    // R5: a lockout never coexists with an enabled gate
    a_r5_far_gate: assert property (@(posedge clk) disable iff (rst)
        far_o |-> !gate_en_o);

endmodule

// File: tb/oc_retry_ctrl_bench.sv
module oc_retry_ctrl_bench;

    localparam int FT = 5;
    localparam int RT = 20;
    localparam int MR = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mrst_i = 1'b0;
    logic oc_i = 1'b0;
    logic pg_i = 1'b0;
    logic limit_i = 1'b0;
    logic gate_en_o, far_o, thr_relax_o;

    int total = 0;
    int fails = 0;
    int n_done = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    oc_retry_ctrl #(
        .TICK_DIV(1), .FILT_TICKS(FT), .RETRY_TICKS(RT), .MAX_RETRY(MR)
    ) u_oc_retry_ctrl (
        .clk(clk), .rst(rst), .mrst_i(mrst_i), .oc_i(oc_i), .pg_i(pg_i),
        .limit_i(limit_i), .gate_en_o(gate_en_o), .far_o(far_o),
        .thr_relax_o(thr_relax_o)
    );

    // {pulse length, trip expected}
    localparam logic [8:0] VEC [0:6] = '{
        {8'd1, 1'b0}, {8'd3, 1'b0}, {8'd4, 1'b0}, {8'd5, 1'b0},
        {8'd6, 1'b1}, {8'd7, 1'b1}, {8'd12, 1'b1}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    // move to the point where t edges have passed since the origin
    task automatic go(input int t);
        adv(t - n_done);
        n_done = t;
    endtask

    task automatic origin();
        n_done = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1; mrst_i = 1'b0; oc_i = 1'b0; pg_i = 1'b0;
        adv(2);
        rst = 1'b0;
        adv(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL R9 watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        limit_i = 1'b0;
        do_reset();
        chk("R9 gate after reset", gate_en_o, 1'b1);
        chk("R9 far after reset", far_o, 1'b0);
        chk("R9 relax after reset", thr_relax_o, 1'b1);

        // R1: pulse length table
        for (int i = 0; i < 7; i++) begin
            int len;
            len = int'(VEC[i][8:1]);
            do_reset();
            origin();
            oc_i = 1'b1;
            go(len);
            oc_i = 1'b0;
            go(10);
            chk($sformatf("R1 pulse len %0d gate", len), gate_en_o, !VEC[i][0]);
        end

        // R1 R2 R3 R5: persistent fault, limited mode
        limit_i = 1'b1;
        do_reset();
        origin();
        oc_i = 1'b1;
        go(7);   chk("R1 gate before filter expiry", gate_en_o, 1'b1);
        go(8);   chk("R1 R2 gate off after trip", gate_en_o, 1'b0);
        go(27);  chk("R2 gate still off at end of backoff", gate_en_o, 1'b0);
        go(28);  chk("R2 gate back on after backoff", gate_en_o, 1'b1);
        go(33);  chk("R3 gate on during retry window", gate_en_o, 1'b1);
        go(34);  chk("R3 re-trip after filter window", gate_en_o, 0);
        go(137); chk("R5 no lock before last trip", far_o, 1'b0);
        go(138); chk("R5 lock after last retry", far_o, 1'b1);
        go(200); chk("R5 gate held off after lock", gate_en_o, 1'b0);
        chk("R5 far held", far_o, 1'b1);

        // R6: manual reset clears the lockout, fault still present
        mrst_i = 1'b1;
        adv(1);
        chk("R6 far cleared by manual reset", far_o, 1'b0);
        chk("R6 gate off during manual reset", gate_en_o, 1'b0);
        adv(3);
        chk("R6 gate off while held", gate_en_o, 1'b0);
        mrst_i = 1'b0;
        #1;
        chk("R6 gate on at release", gate_en_o, 1'b1);
        origin();
        go(5);   chk("R6 R1 gate on within filter after release", gate_en_o, 1'b1);
        go(6);   chk("R6 R1 re-trip after release", gate_en_o, 1'b0);

        // R4: unlimited mode
        limit_i = 1'b0;
        do_reset();
        origin();
        oc_i = 1'b1;
        go(140); chk("R4 no lock in unlimited mode", far_o, 1'b0);
        go(163); chk("R4 gate on in seventh window", gate_en_o, 1'b1);
        go(164); chk("R4 seventh trip", gate_en_o, 1'b0);
        go(184); chk("R4 retries continue", gate_en_o, 1'b1);
        chk("R4 far still low", far_o, 1'b0);

        // R7: threshold select
        do_reset();
        chk("R7 relaxed before power-good", thr_relax_o, 1'b1);
        pg_i = 1'b1;
        adv(1);
        chk("R7 normal after power-good", thr_relax_o, 1'b0);
        pg_i = 1'b0;
        adv(3);
        chk("R7 stays normal when power-good drops", thr_relax_o, 1'b0);
        mrst_i = 1'b1;
        adv(1);
        mrst_i = 1'b0;
        adv(1);
        chk("R7 relaxed after manual reset", thr_relax_o, 1'b1);
        pg_i = 1'b1;
        adv(1);
        pg_i = 1'b0;
        rst = 1'b1;
        adv(1);
        rst = 1'b0;
        adv(1);
        chk("R7 relaxed after power-on reset", thr_relax_o, 1'b1);

        // R8: retry count cleared by a clean power-good window
        limit_i = 1'b1;
        do_reset();
        origin();
        oc_i = 1'b1;
        go(65);
        oc_i = 1'b0;
        go(82);
        chk("R8 gate on after third backoff", gate_en_o, 1'b1);
        pg_i = 1'b1;
        go(92);
        pg_i = 1'b0;
        go(95);
        origin();
        oc_i = 1'b1;
        go(61);  chk("R8 no early lock after clear", far_o, 1'b0);
        go(137); chk("R8 R5 no lock one edge early", far_o, 1'b0);
        go(138); chk("R8 R5 full retry budget restored", far_o, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule